// File: doc/BRIEF.md
# Dual-Lane Switchable Serial Port

This block is a framed serial port with two data lanes that share one bit clock and one frame sync. A single direction setting turns the whole data path of both lanes into either a transmitter or a receiver. The other direction stays inert: its host handshake never asserts and its pin stays low. Each lane keeps a two-word queue in front of one shift register, and that register serves whichever direction is selected. A word can be 3 to 32 bits long and can be shifted with either end first.

The bit clock and frame sync come from outside, synchronous to the system clock, and are oversampled. Data is launched after a rising bit-clock edge and captured on a falling one. A word begins one bit period after the period in which the frame is marked. In basic framing, a high level of the sync marks the frame. In stereo framing, any change of the sync level marks it, and word lengths below 8 are rejected.

On the host side, each lane has a valid/ready word stream in each direction. In transmit, a word is taken on any cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low while the lane's queue holds two words. In receive, `rx_valid` stays high and `rx_data` stays unchanged until the host takes the word with `rx_ready`. A word that arrives while the queue is full is lost; the port does not stall the serial side.

Top module: `duo_serial_port`

## Requirements
- R1: With `cfg_dir_tx`=0 only the receive path works: `tx_ready` is 0 and `sdata_o` and `sdata_oe` are 0. With `cfg_dir_tx`=1, `rx_valid` is 0 and `sdata_oe` is 1.
- R2: Each lane moves its own word in every frame. A lane whose bit in `cfg_lane_en` (bit 0 = lane A, bit 1 = lane B) is 0 moves nothing.
- R3: `cfg_len_m1` holds the word length minus one. Values 2 to 31 work. A value of 0 or 1 sets `cfg_err`, and the port then neither shifts nor handshakes.
- R4: `cfg_lsb_first`=1 sends and receives bit 0 of the word first. With 0, bit (length-1) goes first.
- R5: With `cfg_stereo`=1, every change in the sampled level of `fsync` starts a word, and a length below 8 (`cfg_len_m1` < 7) sets `cfg_err`.
- R6: A received word shorter than 32 bits appears in the low bits of `rx_data` with the upper bits zero.
- R7: In transmit, a frame that starts while the lane's queue is empty sends the previous word again and sets that lane's sticky `tx_underflow` bit.
- R8: In receive, a word that completes while the lane's queue holds two words is dropped, the queued words are kept, and the lane's sticky `rx_overflow` bit is set.
- R9: Direction, length, order, framing and lane enables are latched only while `en`=0. Changes while `en`=1 have no effect.
- R10: `en`=0 empties both queues, clears the shift state and clears `cfg_err`, `tx_underflow` and `rx_overflow`.
- R11: Transmit bits change only in the cycle after a rising `sclk` is seen. In basic framing, a frame is marked by `fsync`=1 at a falling edge, and the first bit occupies the next bit period.
- R12: `rx_data` holds steady while `rx_valid`=1 and `rx_ready`=0. `tx_ready` is 0 while the lane's queue holds two words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low flushes and opens the configuration latch |
| cfg_dir_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_lsb_first | input | 1 | 1 = bit 0 first |
| cfg_stereo | input | 1 | 1 = level-change framing with 8-bit minimum |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_lane_en | input | 2 | Per-lane enable |
| tx_valid | input | 2 | Host word offered, per lane |
| tx_data | input | 2x32 | Host transmit words |
| tx_ready | output | 2 | Lane can take a word |
| rx_valid | output | 2 | Received word available |
| rx_data | output | 2x32 | Received words, right-justified |
| rx_ready | input | 2 | Host takes the received word |
| sclk | input | 1 | Bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync |
| sdata_i | input | 2 | Serial data in, per lane |
| sdata_o | output | 2 | Serial data out, per lane |
| sdata_oe | output | 1 | Serial outputs driven |
| cfg_err | output | 1 | Illegal length for the chosen framing |
| tx_underflow | output | 2 | Sticky resend flag, per lane |
| rx_overflow | output | 2 | Sticky drop flag, per lane |

## Verification
The properties check the following on every cycle: the idle direction stays quiet, an illegal length blocks all traffic, the latched settings stay frozen while enabled, and the error flags never clear while the port is enabled. They also check that a held receive word stays unchanged under back-pressure and that transmit pins move only after a rising bit clock. Whether each bit lands in the right position cannot be seen at that level. That needs the bench's frames, which sweep every length from 3 to 32 in both orders and both directions. The bench scenarios are also the only evidence for a repeated word on underflow, for keeping the older words on overflow, and for the right-justified zero fill.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} sp_dir_e;

  typedef struct packed {
    sp_dir_e dir;
    logic    lsb_first;
    logic    stereo;
  } sp_mode_t;

  localparam int MIN_LEN_BASIC  = 3;
  localparam int MIN_LEN_STEREO = 8;
endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic fsync,
  input  logic stereo,
  output logic rise,
  output logic fall,
  output logic start
);
  logic sclk_q;
  logic fs_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      fs_lvl <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (fall) fs_lvl <= fsync;
    end
  end

  assign rise  = sclk & ~sclk_q;
  assign fall  = ~sclk & sclk_q;
  // stereo framing reacts to a level change, basic framing to a high level
  assign start = fall & (stereo ? (fsync ^ fs_lvl) : fsync);
endmodule

// File: rtl/sp_wordq.sv
module sp_wordq #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/sp_lane.sv
module sp_lane #(
  parameter int W     = 32,
  parameter int DEPTH = 2,
  parameter int LW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          run,
  input  logic          dir_tx,
  input  logic          lsb_first,
  input  logic [LW-1:0] len_m1,
  input  logic          rise,
  input  logic          fall,
  input  logic          start,
  input  logic          tx_valid,
  input  logic [W-1:0]  tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [W-1:0]  rx_data,
  input  logic          rx_ready,
  input  logic          sd_i,
  output logic          sd_o,
  output logic          underflow,
  output logic          overflow
);
  localparam logic [LW:0] FULL_LEN = (LW + 1)'(W);

  logic [W-1:0] shreg, last_q, head, tx_word, rx_next, rx_word, q_din;
  logic [LW:0]  cnt, len, shamt;
  logic         tx_mode, rx_mode, rx_done, q_push, q_pop, empty, full;

  assign len     = {1'b0, len_m1} + 1'b1;
  assign shamt   = FULL_LEN - len;
  assign tx_mode = run & dir_tx;
  assign rx_mode = run & ~dir_tx;

  // transmit source: queue head, or the previous word when starved
  assign tx_word = empty ? last_q : head;

  // receive shift: new bit enters at the end opposite the one that leaves first
  assign rx_next = lsb_first ? {sd_i, shreg[W-1:1]} : {shreg[W-2:0], sd_i};
  assign rx_word = lsb_first ? (rx_next >> shamt) : rx_next;
  assign rx_done = rx_mode & fall & (cnt == (LW + 1)'(1));

  assign q_push = tx_mode ? (tx_valid & ~full) : (rx_done & ~full);
  assign q_din  = tx_mode ? tx_data : rx_word;
  assign q_pop  = tx_mode ? (start & ~empty) : (rx_mode & rx_ready & ~empty);

  sp_wordq #(.W(W), .DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (q_push),
    .din   (q_din),
    .pop   (q_pop),
    .head  (head),
    .empty (empty),
    .full  (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      last_q    <= '0;
      cnt       <= '0;
      sd_o      <= 1'b0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else if (flush) begin
      shreg     <= '0;
      last_q    <= '0;
      cnt       <= '0;
      sd_o      <= 1'b0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else if (tx_mode) begin
      if (start) begin
        shreg  <= lsb_first ? tx_word : (tx_word << shamt);
        last_q <= tx_word;
        cnt    <= len;
        if (empty) underflow <= 1'b1;
      end else if (rise) begin
        if (cnt != '0) begin
          sd_o  <= lsb_first ? shreg[0] : shreg[W-1];
          shreg <= lsb_first ? (shreg >> 1) : (shreg << 1);
          cnt   <= cnt - 1'b1;
        end else begin
          sd_o <= 1'b0;
        end
      end
    end else if (rx_mode && fall) begin
      if (cnt != '0) begin
        shreg <= rx_next;
        cnt   <= cnt - 1'b1;
      end
      if (rx_done && full) overflow <= 1'b1;
      if (start) begin
        shreg <= '0;
        cnt   <= len;
      end
    end
  end

  assign tx_ready = tx_mode & ~full;
  assign rx_valid = rx_mode & ~empty;
  assign rx_data  = head;
endmodule

// File: rtl/duo_serial_port.sv
module duo_serial_port
  import sp_pkg::*;
#(
  parameter int W     = 32,
  parameter int LANES = 2,
  parameter int DEPTH = 2,
  localparam int LW   = $clog2(W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      cfg_dir_tx,
  input  logic                      cfg_lsb_first,
  input  logic                      cfg_stereo,
  input  logic [LW-1:0]             cfg_len_m1,
  input  logic [LANES-1:0]          cfg_lane_en,
  input  logic [LANES-1:0]          tx_valid,
  input  logic [LANES-1:0][W-1:0]   tx_data,
  output logic [LANES-1:0]          tx_ready,
  output logic [LANES-1:0]          rx_valid,
  output logic [LANES-1:0][W-1:0]   rx_data,
  input  logic [LANES-1:0]          rx_ready,
  input  logic                      sclk,
  input  logic                      fsync,
  input  logic [LANES-1:0]          sdata_i,
  output logic [LANES-1:0]          sdata_o,
  output logic                      sdata_oe,
  output logic                      cfg_err,
  output logic [LANES-1:0]          tx_underflow,
  output logic [LANES-1:0]          rx_overflow
);
  sp_mode_t         mode_q;
  logic [LW-1:0]    len_q;
  logic [LANES-1:0] lane_en_q;
  logic             err_q, bad_len, run_port, dir_tx;
  logic             rise, fall, start;

  // settings open only while the port is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '{dir: DIR_RX, lsb_first: 1'b0, stereo: 1'b0};
      len_q     <= LW'(W - 1);
      lane_en_q <= '0;
      err_q     <= 1'b0;
    end else if (!en) begin
      mode_q    <= '{dir: sp_dir_e'(cfg_dir_tx), lsb_first: cfg_lsb_first, stereo: cfg_stereo};
      len_q     <= cfg_len_m1;
      lane_en_q <= cfg_lane_en;
      err_q     <= 1'b0;
    end else if (bad_len) begin
      err_q <= 1'b1;
    end
  end

  assign bad_len  = (int'(len_q) + 1 < MIN_LEN_BASIC) ||
                    (mode_q.stereo && (int'(len_q) + 1 < MIN_LEN_STEREO));
  assign run_port = en & ~err_q & ~bad_len;
  assign dir_tx   = (mode_q.dir == DIR_TX);
  assign sdata_oe = run_port & dir_tx;
  assign cfg_err  = err_q;

  sp_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk),
    .fsync  (fsync),
    .stereo (mode_q.stereo),
    .rise   (rise),
    .fall   (fall),
    .start  (start)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sp_lane #(.W(W), .DEPTH(DEPTH), .LW(LW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (~en),
      .run       (run_port & lane_en_q[i]),
      .dir_tx    (dir_tx),
      .lsb_first (mode_q.lsb_first),
      .len_m1    (len_q),
      .rise      (rise),
      .fall      (fall),
      .start     (start),
      .tx_valid  (tx_valid[i]),
      .tx_data   (tx_data[i]),
      .tx_ready  (tx_ready[i]),
      .rx_valid  (rx_valid[i]),
      .rx_data   (rx_data[i]),
      .rx_ready  (rx_ready[i]),
      .sd_i      (sdata_i[i]),
      .sd_o      (sdata_o[i]),
      .underflow (tx_underflow[i]),
      .overflow  (rx_overflow[i])
    );
  end
endmodule

// File: rtl/duo_serial_port_chk.sv
module duo_serial_port_chk #(
  parameter int W     = 32,
  parameter int LANES = 2,
  localparam int LW   = $clog2(W)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    sclk,
  input logic                    dir_tx,
  input logic [LW-1:0]           len_q,
  input logic                    cfg_err,
  input logic [LANES-1:0]        tx_ready,
  input logic [LANES-1:0]        rx_valid,
  input logic [LANES-1:0]        rx_ready,
  input logic [LANES-1:0][W-1:0] rx_data,
  input logic [LANES-1:0]        sdata_o,
  input logic [LANES-1:0]        tx_underflow,
  input logic [LANES-1:0]        rx_overflow
);
  assert_rx_quiet_in_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dir_tx |-> (rx_valid == '0));

  assert_tx_quiet_in_rx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dir_tx) |-> (tx_ready == '0 && sdata_o == '0));

  assert_err_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (tx_ready == '0 && rx_valid == '0 && sdata_o == '0));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(len_q) && $stable(dir_tx)));

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_valid == '0 && tx_underflow == '0 && rx_overflow == '0 && !cfg_err));

  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (($past(tx_underflow) & ~tx_underflow) == '0));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (($past(rx_overflow) & ~rx_overflow) == '0));

  assert_launch_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (sdata_o != $past(sdata_o))) |-> ($past(sclk) && !$past(sclk, 2)));

  for (genvar i = 0; i < LANES; i++) begin : g_hold
    assert_rx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n || !en)
      (rx_valid[i] && !rx_ready[i]) |=> (rx_valid[i] && $stable(rx_data[i])));
  end
endmodule

bind duo_serial_port duo_serial_port_chk #(.W(W), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .sclk         (sclk),
  .dir_tx       (dir_tx),
  .len_q        (len_q),
  .cfg_err      (cfg_err),
  .tx_ready     (tx_ready),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_data      (rx_data),
  .sdata_o      (sdata_o),
  .tx_underflow (tx_underflow),
  .rx_overflow  (rx_overflow)
);

// File: tb/tb_duo_serial_port.sv
module tb_duo_serial_port;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              cfg_dir_tx = 1'b0, cfg_lsb_first = 1'b0, cfg_stereo = 1'b0;
  logic [4:0]        cfg_len_m1 = 5'd7;
  logic [1:0]        cfg_lane_en = 2'b11;
  logic [1:0]        tx_valid = '0, tx_ready, rx_valid, rx_ready = '0;
  logic [1:0][31:0]  tx_data = '0, rx_data;
  logic              sclk = 1'b0, fsync = 1'b0, sdata_oe, cfg_err;
  logic [1:0]        sdata_i = '0, sdata_o, tx_underflow, rx_overflow;
  logic              fs_lvl = 1'b0;
  int                n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  duo_serial_port dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_dir_tx(cfg_dir_tx),
    .cfg_lsb_first(cfg_lsb_first), .cfg_stereo(cfg_stereo), .cfg_len_m1(cfg_len_m1),
    .cfg_lane_en(cfg_lane_en), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sclk(sclk), .fsync(fsync), .sdata_i(sdata_i), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .cfg_err(cfg_err), .tx_underflow(tx_underflow),
    .rx_overflow(rx_overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int s);
    return (32'h9E37_79B9 * 32'(s)) ^ (32'h1234_5678 + (32'(s) << 7));
  endfunction

  function automatic logic [31:0] lmask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  task automatic cfg_port(input bit tx, input int len, input bit lsb, input bit st, input logic [1:0] lanes);
    @(negedge clk);
    en = 1'b0;
    cfg_dir_tx = tx; cfg_len_m1 = 5'(len - 1); cfg_lsb_first = lsb;
    cfg_stereo = st; cfg_lane_en = lanes;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  // one bit period: rise with new fsync/data, hold, fall (capture pins), hold
  task automatic bitp(input logic fs, input logic [1:0] din, output logic [1:0] dout);
    @(negedge clk);
    sclk = 1'b1; fsync = fs; sdata_i = din; fs_lvl = fs;
    @(negedge clk);
    @(negedge clk);
    sclk = 1'b0;
    dout = sdata_o;
    @(negedge clk);
  endtask

  task automatic frame(input int len, input bit lsb, input bit st,
                       input logic [1:0][31:0] w, output logic [1:0][31:0] got);
    logic [1:0] d;
    got = '0;
    bitp(st ? ~fs_lvl : 1'b1, 2'b00, d);
    for (int k = 0; k < len; k++) begin
      int idx;
      idx = lsb ? k : len - 1 - k;
      bitp(st ? fs_lvl : 1'b0, {w[1][idx], w[0][idx]}, d);
      got[0][idx] = d[0];
      got[1][idx] = d[1];
    end
  endtask

  task automatic push2(input logic [1:0][31:0] w, input string tag);
    @(negedge clk);
    chk(tx_ready == 2'b11, tag, 32'(tx_ready), 32'h3);
    tx_valid = 2'b11; tx_data = w;
    @(negedge clk);
    tx_valid = 2'b00;
  endtask

  task automatic pop2;
    @(negedge clk);
    rx_ready = 2'b11;
    @(negedge clk);
    rx_ready = 2'b00;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [1:0][31:0] w1, w2, w3, g;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 0 && rx_valid == 0 && sdata_o == 0 && sdata_oe == 0, "R1 reset quiet",
        {tx_ready, rx_valid, sdata_o, 25'd0, sdata_oe}, 32'h0);
    chk(cfg_err == 0 && tx_underflow == 0 && rx_overflow == 0, "R10 reset flags",
        {cfg_err, tx_underflow, rx_overflow}, 32'h0);

    // sweep: both directions, every length, both orders
    for (int d = 0; d < 2; d++) begin
      for (int len = 3; len <= 32; len++) begin
        for (int o = 0; o < 2; o++) begin
          bit st;
          logic [31:0] m;
          st = (len >= 8) && (len % 4 == 1);
          m  = lmask(len);
          w1 = {pat(len * 8 + o * 2 + 1), pat(len * 8 + o * 2)};
          w2 = {pat(len * 8 + o * 2 + 5), pat(len * 8 + o * 2 + 4)};
          cfg_port(d[0], len, o[0], st, 2'b11);
          chk(cfg_err == 0 && sdata_oe == d[0], $sformatf("R3 legal len=%0d oe", len),
              {cfg_err, sdata_oe}, {1'b0, d[0]});
          if (d == 1) begin
            chk(rx_valid == 0, "R1 no rx in tx", 32'(rx_valid), 0);
            push2(w1, "R12 tx accept");
            push2(w2, "R12 tx accept");
            @(negedge clk);
            chk(tx_ready == 0, "R12 ready low when queue full", 32'(tx_ready), 0);
            frame(len, o[0], st, '0, g);
            for (int i = 0; i < 2; i++)
              chk(g[i] == (w1[i] & m), $sformatf("R4/R11 tx len=%0d lsb=%0d st=%0d lane=%0d w1", len, o, st, i), g[i], w1[i] & m);
            frame(len, o[0], st, '0, g);
            for (int i = 0; i < 2; i++)
              chk(g[i] == (w2[i] & m), $sformatf("R4/R2 tx len=%0d lsb=%0d lane=%0d w2", len, o, i), g[i], w2[i] & m);
          end else begin
            chk(tx_ready == 0, "R1 no tx in rx", 32'(tx_ready), 0);
            frame(len, o[0], st, w1, g);
            for (int i = 0; i < 2; i++)
              chk(rx_valid[i] && rx_data[i] == (w1[i] & m),
                  $sformatf("R6/R4 rx len=%0d lsb=%0d st=%0d lane=%0d", len, o, st, i), rx_data[i], w1[i] & m);
            pop2();
            frame(len, o[0], st, w2, g);
            for (int i = 0; i < 2; i++)
              chk(rx_valid[i] && rx_data[i] == (w2[i] & m),
                  $sformatf("R6/R2 rx len=%0d lsb=%0d lane=%0d second", len, o, i), rx_data[i], w2[i] & m);
            pop2();
          end
        end
      end
    end

    // lane enable
    cfg_port(1'b0, 8, 1'b0, 1'b0, 2'b01);
    frame(8, 1'b0, 1'b0, {32'h5A, 32'hC3}, g);
    chk(rx_valid == 2'b01 && rx_data[0] == 32'hC3, "R2 only lane A", {rx_valid, rx_data[0][29:0]}, {2'b01, 30'hC3});

    // illegal length
    cfg_port(1'b1, 2, 1'b0, 1'b0, 2'b11);
    @(negedge clk);
    chk(cfg_err == 1 && tx_ready == 0, "R3 illegal length", {cfg_err, tx_ready}, 32'h4);
    frame(8, 1'b0, 1'b0, '0, g);
    chk(g == '0 && sdata_oe == 0, "R3 no shifting", g[0] | g[1], 0);

    // stereo minimum
    cfg_port(1'b0, 7, 1'b0, 1'b1, 2'b11);
    @(negedge clk);
    chk(cfg_err == 1, "R5 stereo len 7 rejected", 32'(cfg_err), 1);
    cfg_port(1'b0, 8, 1'b0, 1'b1, 2'b11);
    @(negedge clk);
    chk(cfg_err == 0, "R5 stereo len 8 accepted", 32'(cfg_err), 0);
    frame(8, 1'b0, 1'b1, {32'h81, 32'h7E}, g);
    chk(rx_valid == 2'b11 && rx_data[1] == 32'h81, "R5 level-change frame", rx_data[1], 32'h81);
    pop2();

    // underflow resend
    cfg_port(1'b1, 8, 1'b0, 1'b0, 2'b11);
    @(negedge clk);
    tx_valid = 2'b11; tx_data = {32'h3C, 32'h5A};
    @(negedge clk);
    tx_valid = 2'b00;
    frame(8, 1'b0, 1'b0, '0, g);
    chk(g[0] == 32'h5A && tx_underflow == 0, "R7 first word no flag", {tx_underflow, g[0][29:0]}, 32'h5A);
    frame(8, 1'b0, 1'b0, '0, g);
    chk(g[0] == 32'h5A && g[1] == 32'h3C, "R7 resend previous", {g[1][15:0], g[0][15:0]}, 32'h003C_005A);
    chk(tx_underflow == 2'b11, "R7 underflow flag", 32'(tx_underflow), 3);

    // overflow drop
    cfg_port(1'b0, 8, 1'b1, 1'b0, 2'b11);
    w1 = {32'h11, 32'h21}; w2 = {32'h12, 32'h22}; w3 = {32'h13, 32'h23};
    frame(8, 1'b1, 1'b0, w1, g);
    frame(8, 1'b1, 1'b0, w2, g);
    chk(rx_overflow == 0, "R8 no flag while room", 32'(rx_overflow), 0);
    frame(8, 1'b1, 1'b0, w3, g);
    chk(rx_overflow == 2'b11, "R8 overflow flag", 32'(rx_overflow), 3);
    chk(rx_data[0] == 32'h21, "R8 oldest kept", rx_data[0], 32'h21);
    pop2();
    chk(rx_data[0] == 32'h22 && rx_data[1] == 32'h12, "R8 second kept", rx_data[0], 32'h22);

    // flush on disable
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(rx_valid == 0 && rx_overflow == 0, "R10 disable clears", {rx_valid, rx_overflow}, 0);
    en = 1'b1;
    @(negedge clk);
    chk(rx_valid == 0, "R10 queue emptied", 32'(rx_valid), 0);

    // changes while enabled are ignored
    cfg_port(1'b0, 8, 1'b0, 1'b0, 2'b11);
    @(negedge clk);
    cfg_len_m1 = 5'd15; cfg_dir_tx = 1'b1; cfg_lane_en = 2'b00;
    frame(8, 1'b0, 1'b0, {32'hA7, 32'h3B}, g);
    chk(rx_valid == 2'b11 && rx_data[0] == 32'h3B && sdata_oe == 0, "R9 settings frozen", rx_data[0], 32'h3B);

    summary();
    $finish;
  end
endmodule